// File: doc/BRIEF.md
# Line Pulse Density Violation Monitor

This block watches the decoded bit stream of a received line, one bit per strobe, where 1 stands for a pulse and 0 for its absence. It applies two rules to every received bit. The first rule flags a run of too many consecutive zeros. The second rule is a family of density checks: for every N from 1 to 23, each span of 8(N+1) consecutive bits must hold at least N ones. A bit that breaks either rule produces a one-cycle violation pulse.

The pulse sets a sticky status flag, which a host clears with a clear strobe. An interrupt line shows the status flag only while the mask input is 1. Line decoding, framing, counters and any register access are handled outside the block.

The density family is tracked by keeping the age, in received bits, of each of the 23 latest ones. The rule for N fails when the N-th latest one is 8(N+1) or more bits old. Ages saturate, so a one that never arrived reads as infinitely old. Each rule stays silent until enough bits have been received since reset to fill its span.

Top module: `pdv_monitor`

## Requirements
- R1: When a strobed 0 makes the current zero run reach 16 bits, a violation is flagged for that bit. Every further strobed 0 in the same run is also flagged. A strobed 1 ends the run.
- R2: For each N from 1 to 23, a strobed bit is flagged when the last 8(N+1) strobed bits, counting that bit, contain fewer than N ones.
- R3: The density rule for a given N reports nothing until at least 8(N+1) bits have been strobed since reset.
- R4: A cycle with `bit_vld_i` low changes no tracking state, and `viol_o` is low in the cycle that follows it.
- R5: `viol_o` is high for exactly the one clock cycle after the edge that accepted a flagged bit.
- R6: `stat_o` sets on each violation and then stays at 1 until a cycle with `stat_clr_i` high and no new violation.
- R7: If a violation and `stat_clr_i` occur in the same cycle, `stat_o` is 1 afterwards.
- R8: `irq_o` equals `stat_o` AND `irq_mask_i`, so it stays low while the mask is 0.
- R9: A stream of all ones never causes a violation. A repeating pattern of one 1 followed by seven 0s never causes a violation.
- R10: While reset is held, and right after it, `viol_o`, `stat_o` and `irq_o` are 0 and no bit history remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: a received bit is present this cycle |
| bit_i | input | 1 | Received bit, 1 = pulse |
| irq_mask_i | input | 1 | Interrupt enable, 1 = unmasked |
| stat_clr_i | input | 1 | Host clear of the sticky status |
| viol_o | output | 1 | One-cycle violation pulse |
| stat_o | output | 1 | Sticky violation status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions check several properties on every cycle. The stored ages of the latest ones stay ordered from newest to oldest. A strobed 1 clears the zero run. No density rule fires in the first 15 bits after reset. No pulse follows a cycle without a strobe. The status flag holds without a clear and is always set after a pulse. The interrupt stays low while masked. The exact bit on which each rule first fails can only be shown by the bench scenarios. These compare every cycle against a model that counts the ones in each window directly. The scenarios include a start-up check, zero runs split by idle cycles, sparse periodic patterns, streams that pass, a clear that collides with a violation, and long random streams.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
    // Default rule set: density spans 8(N+1) for N = 1..23, zero run limit 16
    localparam int PDV_NMAX = 23;
    localparam int PDV_UNIT = 8;
    localparam int PDV_ZLIM = 16;

    typedef struct packed {
        logic viol;
        logic stat;
    } pdv_flags_t;
endpackage

// File: rtl/pdv_zero_run.sv
module pdv_zero_run #(
    parameter int ZLIM = pdv_pkg::PDV_ZLIM
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int CW = $clog2(ZLIM + 1);
    localparam logic [CW-1:0] LIM = CW'(ZLIM);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        hit_o = 1'b0;
        if (vld_i) begin
            if (bit_i) begin
                run_d = '0;
            end else if (run_q != LIM) begin
                run_d = run_q + 1'b1;
            end
            hit_o = !bit_i && (run_d == LIM);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    // R1: a strobed one always ends the current zero run
    a_r1_one_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && bit_i) |=> (run_q == '0));
endmodule

// File: rtl/pdv_density_track.sv
module pdv_density_track #(
    parameter int NMAX = pdv_pkg::PDV_NMAX,
    parameter int UNIT = pdv_pkg::PDV_UNIT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int WMAX = UNIT * (NMAX + 1);
    localparam int AW   = $clog2(WMAX + 1);
    localparam logic [AW-1:0] AGE_SAT = {AW{1'b1}};
    localparam logic [AW-1:0] SEEN_MAX = AW'(WMAX);

    typedef struct packed {
        logic [NMAX-1:0][AW-1:0] age;   // age[k]: bits since the (k+1)-th latest one
        logic [AW-1:0]           seen;  // strobed bits since reset, saturating
    } trk_t;

    trk_t d, q;

    function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] a);
        return (a == AGE_SAT) ? a : a + 1'b1;
    endfunction

    always_comb begin
        d     = q;
        hit_o = 1'b0;
        if (vld_i) begin
            if (bit_i) begin
                d.age[0] = '0;
                for (int k = 1; k < NMAX; k++) d.age[k] = sat_inc(q.age[k-1]);
            end else begin
                for (int k = 0; k < NMAX; k++) d.age[k] = sat_inc(q.age[k]);
            end
            d.seen = (q.seen == SEEN_MAX) ? q.seen : q.seen + 1'b1;
            for (int n = 1; n <= NMAX; n++) begin
                if ((d.seen >= AW'(UNIT * (n + 1))) && (d.age[n-1] >= AW'(UNIT * (n + 1))))
                    hit_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.age  <= '1;
            q.seen <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: stored ones stay ordered newest to oldest
    for (genvar k = 1; k < NMAX; k++) begin : g_order
        a_r2_age_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
            q.age[k-1] <= q.age[k]);
    end

    // R3: nothing reported before the shortest span can be full
    a_r3_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.seen < AW'(2 * UNIT - 1)) |-> !hit_o);
endmodule

// File: rtl/pdv_monitor.sv
module pdv_monitor #(
    parameter int NMAX = pdv_pkg::PDV_NMAX,
    parameter int UNIT = pdv_pkg::PDV_UNIT,
    parameter int ZLIM = pdv_pkg::PDV_ZLIM
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic irq_mask_i,
    input  logic stat_clr_i,
    output logic viol_o,
    output logic stat_o,
    output logic irq_o
);
    import pdv_pkg::*;

    logic zr_hit, dn_hit;
    pdv_flags_t d, q;

    pdv_zero_run #(.ZLIM(ZLIM)) u_zero (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (bit_vld_i),
        .bit_i (bit_i),
        .hit_o (zr_hit)
    );

    pdv_density_track #(.NMAX(NMAX), .UNIT(UNIT)) u_dens (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .vld_i (bit_vld_i),
        .bit_i (bit_i),
        .hit_o (dn_hit)
    );

    always_comb begin
        d      = q;
        d.viol = bit_vld_i && (zr_hit || dn_hit);
        d.stat = (q.stat && !stat_clr_i) || d.viol;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign viol_o = q.viol;
    assign stat_o = q.stat;
    assign irq_o  = q.stat && irq_mask_i;

    // R4: no pulse after a cycle without a strobe
    a_r4_idle_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_vld_i |=> !viol_o);
    // R6: status holds while no clear is given
    a_r6_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o && !stat_clr_i) |=> stat_o);
    // R7: a pulse always leaves the status set, even against a clear
    a_r7_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_o |-> stat_o);
    // R8: a masked interrupt stays low
    a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_mask_i |-> !irq_o);
endmodule

// File: tb/pdv_monitor_test.sv
module pdv_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0, bin = 1'b0, mask = 1'b0, clr = 1'b0;
    logic viol, stat, irq;

    int checks = 0;
    int errors = 0;

    int hist[$];
    int zrun = 0;
    logic est = 1'b0;
    logic [2:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pdv_monitor uut (
        .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .bit_i(bin),
        .irq_mask_i(mask), .stat_clr_i(clr),
        .viol_o(viol), .stat_o(stat), .irq_o(irq)
    );

    // Reference: counts ones in each window directly
    task automatic model_bit(input logic b, output logic v);
        hist.push_front(b ? 1 : 0);
        if (hist.size() > 192) void'(hist.pop_back());
        zrun = b ? 0 : zrun + 1;
        v = (zrun >= 16);
        for (int n = 1; n <= 23; n++) begin
            int w = 8 * (n + 1);
            if (hist.size() >= w) begin
                int ones = 0;
                for (int i = 0; i < w; i++) ones += hist[i];
                if (ones < n) v = 1'b1;
            end
        end
    endtask

    task automatic drive(input logic v, input logic b, input logic c, input logic m, input string tag);
        logic ev;
        @(negedge clk);
        vld = v; bin = b; clr = c; mask = m;
        ev = 1'b0;
        if (v) model_bit(b, ev);
        est = (est && !c) || ev;
        exp_q.push_back({ev, est, est && m});
        tag_q.push_back(tag);
    endtask

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: viol/stat/irq actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: scoreboard compares each driven cycle's result after its edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({viol, stat, irq}, e, t);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        vld = 0; bin = 0; clr = 0; mask = 0;
        rst_n = 1'b0;
        hist.delete(); zrun = 0; est = 1'b0;
        repeat (2) @(negedge clk);
        check({viol, stat, irq}, 3'b000, "R10 reset held");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        check({viol, stat, irq}, 3'b000, "R10 after reset");
        // R3: fresh start, sparse pattern with period 13 must not fire early
        for (int i = 0; i < 120; i++) drive(1, (i % 13) == 0, 0, 1, "R3 R2 period13 start");

        do_reset();
        for (int i = 0; i < 15; i++) drive(1, 0, 0, 1, "R3 R1 15 zeros from reset");
        drive(1, 0, 0, 1, "R1 16th zero");
        drive(1, 0, 0, 1, "R1 17th zero");
        drive(0, 0, 0, 1, "R5 pulse ends");

        do_reset();
        for (int i = 0; i < 300; i++) drive(1, 1, 0, 1, "R9 all ones");
        for (int i = 0; i < 400; i++) drive(1, (i % 8) == 0, 0, 1, "R9 one in eight");

        // R4: zero run split by idle cycles
        drive(1, 1, 0, 1, "R4 lead one");
        for (int i = 0; i < 10; i++) drive(1, 0, 0, 1, "R4 zeros");
        for (int i = 0; i < 30; i++) drive(0, 0, 0, 1, "R4 idle");
        for (int i = 0; i < 5; i++) drive(1, 0, 0, 1, "R4 zeros resumed");
        drive(1, 0, 0, 1, "R1 R4 16th zero across gap");
        drive(0, 0, 0, 1, "R6 hold idle");
        drive(0, 0, 0, 0, "R8 masked");
        drive(0, 0, 0, 1, "R8 unmasked");
        // R7: clear together with a new violation
        drive(1, 0, 1, 1, "R7 clear vs violation");
        drive(1, 1, 1, 1, "R6 clear");
        drive(0, 0, 0, 1, "R6 stays clear");

        // R2: sparse periodic patterns failing wider spans
        for (int i = 0; i < 300; i++) drive(1, (i % 13) == 0, 0, 1, "R2 period13");
        drive(0, 0, 1, 1, "R6 clear");
        for (int i = 0; i < 300; i++) drive(1, (i % 9) == 0, (i % 50) == 49, i[6], "R2 period9");
        for (int i = 0; i < 3000; i++) begin
            logic r;
            r = ($urandom_range(0, 9) < 2);
            drive($urandom_range(0, 7) != 0, r, $urandom_range(0, 40) == 0,
                  $urandom_range(0, 3) != 0, "R2 random");
        end
        repeat (3) drive(0, 0, 0, 1, "R4 tail");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule